// File: doc/BRIEF.md
# Three-wire serial register target for a display controller

This block is the serial slave of a display controller. Its bus has three wires: an active-low select, a clock, and a single data line that both sides share. A frame starts with a 6-bit register address sent MSB first. A direction flag follows it. The eighth clock is a spare bit on writes. On reads it is a turnaround clock during which the line is left undriven. Eight data bits, MSB first, close the frame.

The bus wires are oversampled in the core clock domain. Bits are taken in on rising serial-clock edges. Read data is launched on falling edges, and the output enable covers only the eight read bits.

Behind the bus sits a four-byte register file:
- a scratch byte used as a communication test;
- a read-only identity byte;
- a control byte whose low bits carry the resolution code;
- a power byte holding an active/standby bit and an ownership bit.

The ownership bit selects where the effective resolution code and the standby level come from. When it is clear, they follow strap pins. When it is set, they come from register contents. The results go to the display core on `res_o` and `active_o`.

Top module: `disp_spi_regs`

## Requirements
- R1: A frame is 16 serial clocks with select low. Bits 1 to 6 are the address, MSB first. Bit 7 is the flag (1 = read, 0 = write). Bit 8 is ignored on writes. Bits 9 to 16 are data, MSB first. A write takes effect only after the 16th rising edge.
- R2: On a read, `sdio_oe_o` stays low through the 8th clock. The 8 data bits are then driven, each changing after a falling edge. `sdio_oe_o` is high for exactly those 8 bits and low again after the frame.
- R3: Register 0x00 is a read/write scratch byte. A value written there reads back unchanged, for example 0x55 and 0xAA.
- R4: Register 0x01 reads {ID_CODE, VERSION}, which is 0x31 with the default parameters. Writes to it have no effect.
- R5: Register 0x02 holds writable bits 7:3. Bits 2:0 read the effective resolution code. While register 0x03 bit 7 is 0, that code follows `strap_res_i`, and writes to bits 2:0 are ignored.
- R6: Register 0x03 bit 0 is the power bit (1 = active, 0 = standby) and drives `active_o`. Bit 7 selects software control. While bit 7 is 0, bit 0 follows `strap_active_i`. A write to register 0x03 stores all eight bits.
- R7: While register 0x03 bit 7 is 1, `res_o` and `active_o` come only from register contents. Changes on the strap pins have no effect on them, and writes to register 0x02 bits 2:0 set `res_o`.
- R8: Raising select before a frame is complete aborts it. No write is committed, and `sdio_oe_o` returns low.
- R9: Addresses 0x04 to 0x3F read as 0x00, and writes to them change nothing.
- R10: After reset, `sdio_oe_o` is low, register 0x00 reads 0x00 and register 0x03 bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Bus select, active low |
| sck_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Read data toward the pad |
| sdio_oe_o | output | 1 | Pad drive enable for read data |
| strap_res_i | input | 3 | Strapped resolution code |
| strap_active_i | input | 1 | Strapped power level, 1 = active |
| res_o | output | 3 | Effective resolution code |
| active_o | output | 1 | Effective power level, 1 = active |

## Verification
The bench writes complementary scratch patterns (0x55, 0xAA) and reads them back. Both bit polarities are therefore seen at every data position, which exposes shift-order and off-by-one faults.

Reads of the identity byte, of unmapped addresses, and after a write to the identity byte separate a working read-only decode from a writable or aliased one. Toggling the strap pins before and after the ownership bit is set shows whether the outputs follow the pins or the registers. Frames aborted part-way through both a write and a read show whether a commit or an enable leaks out of an incomplete frame.

// File: rtl/disp_spi_pkg.sv
package disp_spi_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int RES_W  = 3;

  localparam logic [ADDR_W-1:0] A_TEST = 6'h00;
  localparam logic [ADDR_W-1:0] A_ID   = 6'h01;
  localparam logic [ADDR_W-1:0] A_CFG  = 6'h02;
  localparam logic [ADDR_W-1:0] A_PWR  = 6'h03;

  localparam int PWR_ACT_BIT = 0;
  localparam int PWR_SW_BIT  = 7;
endpackage

// File: rtl/disp_spi_sync.sv
module disp_spi_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_sync
    logic s0_q, s1_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s0_q <= RST_VAL[g];
        s1_q <= RST_VAL[g];
      end else begin
        s0_q <= d_i[g];
        s1_q <= s0_q;
      end
    end
    assign q_o[g] = s1_q;
  end
endmodule

// File: rtl/disp_spi_frame.sv
module disp_spi_frame
  import disp_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sck_s_i,
  input  logic              sdi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam int HDR_W     = ADDR_W + 1;
  localparam int DATA_FST  = ADDR_W + 2;
  localparam int FRAME_LEN = DATA_FST + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] C_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] C_DFST = CNT_W'(DATA_FST);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] C_END  = CNT_W'(FRAME_LEN);

  logic             sck_q;
  logic             rise, fall;
  logic [CNT_W-1:0] cnt_q;
  logic [HDR_W-1:0] hdr_q;
  logic [DATA_W-1:0] wsh_q, osh_q;
  logic             in_data;

  assign rise    = sck_s_i & ~sck_q;
  assign fall    = ~sck_s_i & sck_q;
  assign in_data = (cnt_q >= C_DFST) && (cnt_q < C_END);
  assign addr_o  = hdr_q[HDR_W-1:1];
  assign sdo_o   = osh_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      cnt_q     <= '0;
      hdr_q     <= '0;
      wsh_q     <= '0;
      osh_q     <= '0;
      oe_o      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      sck_q   <= sck_s_i;
      wr_en_o <= 1'b0;
      if (cs_n_s_i) begin
        cnt_q <= '0;
        oe_o  <= 1'b0;
      end else begin
        if (rise) begin
          if (cnt_q < C_HDR) hdr_q <= {hdr_q[HDR_W-2:0], sdi_s_i};
          if (in_data) wsh_q <= {wsh_q[DATA_W-2:0], sdi_s_i};
          if (cnt_q == C_LAST && !hdr_q[0]) begin
            wr_en_o   <= 1'b1;
            wr_data_o <= {wsh_q[DATA_W-2:0], sdi_s_i};
          end
          if (cnt_q < C_END) cnt_q <= cnt_q + 1'b1;
        end
        if (fall) begin
          if (hdr_q[0] && in_data) begin
            oe_o  <= 1'b1;
            osh_q <= (cnt_q == C_DFST) ? rd_data_i : {osh_q[DATA_W-2:0], 1'b0};
          end else begin
            oe_o <= 1'b0;
          end
        end
      end
    end
  end

  // enable run length within one frame
  logic [CNT_W-1:0] oe_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       oe_run_q <= '0;
    else if (cs_n_s_i) oe_run_q <= '0;
    else if (fall && oe_o) oe_run_q <= oe_run_q + 1'b1;
  end

  assert_oe_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_run_q <= CNT_W'(DATA_W));
  assert_oe_off_deselect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> !oe_o);
  assert_write_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  assert_no_drive_on_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !oe_o);
endmodule

// File: rtl/disp_spi_regfile.sv
module disp_spi_regfile
  import disp_spi_pkg::*;
#(
  parameter logic [3:0] ID_CODE = 4'h3,
  parameter logic [3:0] VERSION = 4'h1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [RES_W-1:0]  strap_res_i,
  input  logic              strap_active_i,
  output logic [RES_W-1:0]  res_o,
  output logic              active_o
);
  logic [DATA_W-1:0]       test_q, pwr_q;
  logic [DATA_W-RES_W-1:0] cfg_hi_q;
  logic [RES_W-1:0]        res_q;
  logic                    sw_ctl;

  assign sw_ctl   = pwr_q[PWR_SW_BIT];
  assign res_o    = res_q;
  assign active_o = pwr_q[PWR_ACT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_q   <= '0;
      cfg_hi_q <= '0;
      res_q    <= '0;
      pwr_q    <= '0;
    end else begin
      if (we_i && addr_i == A_TEST) test_q <= wdata_i;
      if (we_i && addr_i == A_CFG) cfg_hi_q <= wdata_i[DATA_W-1:RES_W];
      if (!sw_ctl) res_q <= strap_res_i;
      else if (we_i && addr_i == A_CFG) res_q <= wdata_i[RES_W-1:0];
      if (we_i && addr_i == A_PWR) pwr_q <= wdata_i;
      else if (!sw_ctl) pwr_q[PWR_ACT_BIT] <= strap_active_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_TEST:  rdata_o = test_q;
      A_ID:    rdata_o = {ID_CODE, VERSION};
      A_CFG:   rdata_o = {cfg_hi_q, res_q};
      A_PWR:   rdata_o = pwr_q;
      default: rdata_o = '0;
    endcase
  end

  assert_hw_res_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_ctl |=> res_o == $past(strap_res_i));
  assert_sw_res_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_ctl && !(we_i && addr_i == A_CFG)) |=> $stable(res_o));
  assert_sw_act_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_ctl && !(we_i && addr_i == A_PWR)) |=> $stable(active_o));
  assert_test_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_TEST) |=> $stable(test_q));
endmodule

// File: rtl/disp_spi_regs.sv
module disp_spi_regs
  import disp_spi_pkg::*;
#(
  parameter logic [3:0] ID_CODE = 4'h3,
  parameter logic [3:0] VERSION = 4'h1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             sdio_i,
  output logic             sdio_o,
  output logic             sdio_oe_o,
  input  logic [RES_W-1:0] strap_res_i,
  input  logic             strap_active_i,
  output logic [RES_W-1:0] res_o,
  output logic             active_o
);
  logic [2:0]        bus_s;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;

  disp_spi_sync #(.N(3), .RST_VAL(3'b100)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, sdio_i}),
    .q_o    (bus_s)
  );

  disp_spi_frame i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_s_i  (bus_s[2]),
    .sck_s_i   (bus_s[1]),
    .sdi_s_i   (bus_s[0]),
    .rd_data_i (rd_data),
    .addr_o    (addr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .sdo_o     (sdio_o),
    .oe_o      (sdio_oe_o)
  );

  disp_spi_regfile #(.ID_CODE(ID_CODE), .VERSION(VERSION)) i_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .addr_i         (addr),
    .we_i           (wr_en),
    .wdata_i        (wr_data),
    .rdata_o        (rd_data),
    .strap_res_i    (strap_res_i),
    .strap_active_i (strap_active_i),
    .res_o          (res_o),
    .active_o       (active_o)
  );
endmodule

// File: tb/test_disp_spi_regs.sv
module test_disp_spi_regs;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, sck_i = 1'b0, sdio_i = 1'b0;
  logic       sdio_o, sdio_oe_o;
  logic [2:0] strap_res_i = 3'd0;
  logic       strap_active_i = 1'b0;
  logic [2:0] res_o;
  logic       active_o;

  localparam time HALF = 80ns;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  byte   exp_q[$];
  string tag_q[$];

  always #5ns clk_i = ~clk_i;

  disp_spi_regs i_disp_spi_regs (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(logic b);
    sdio_i = b;
    #HALF sck_i = 1'b1;
    #HALF sck_i = 1'b0;
  endtask

  task automatic send_hdr(logic [5:0] a, logic rd);
    cs_ni = 1'b0;
    #HALF;
    for (int i = 5; i >= 0; i--) clk_bit(a[i]);
    clk_bit(rd);
  endtask

  task automatic end_frame();
    #HALF cs_ni = 1'b1;
    #HALF;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    send_hdr(a, 1'b0);
    clk_bit(1'b1);
    for (int i = 7; i >= 0; i--) clk_bit(d[i]);
    end_frame();
  endtask

  task automatic rd(logic [5:0] a, byte e, string req);
    int oe_hi = 0;
    exp_q.push_back(e);
    tag_q.push_back(req);
    send_hdr(a, 1'b1);
    sdio_i = 1'bx;
    #HALF sck_i = 1'b1;
    #(HALF/2) chk("R2 turnaround oe", sdio_oe_o, 0);
    #(HALF/2) sck_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      #HALF sck_i = 1'b1;
      if (sdio_oe_o) oe_hi++;
      #HALF sck_i = 1'b0;
    end
    #HALF chk("R2 oe low after data", sdio_oe_o, 0);
    chk("R2 oe bit count", oe_hi, 8);
    end_frame();
  endtask

  // monitor: collect driven read bits, compare against expected queue
  logic [7:0] mon_sh;
  int mon_n;
  always @(posedge sck_i or posedge cs_ni) begin
    if (cs_ni) mon_n = 0;
    else if (sdio_oe_o) begin
      mon_sh = {mon_sh[6:0], sdio_o};
      mon_n++;
      if (mon_n == 8) begin
        if (exp_q.size() == 0) chk("R2 unexpected read data", 1, 0);
        else chk(tag_q.pop_front(), int'(mon_sh), int'(exp_q.pop_front()) & 8'hff);
        mon_n = 0;
      end
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R10 oe at reset", sdio_oe_o, 0);
    rd(6'h00, 8'h00, "R10 scratch reset");
    rd(6'h03, 8'h00, "R10 power reg reset");

    wr(6'h00, 8'h55);
    rd(6'h00, 8'h55, "R3 scratch 0x55");
    wr(6'h00, 8'hAA);
    rd(6'h00, 8'hAA, "R3 R1 scratch 0xAA");

    rd(6'h01, 8'h31, "R4 id byte");
    wr(6'h01, 8'hFF);
    rd(6'h01, 8'h31, "R4 id after write");

    strap_res_i = 3'd5;
    repeat (3) @(negedge clk_i);
    chk("R5 res follows strap", res_o, 5);
    rd(6'h02, 8'h05, "R5 cfg read");
    wr(6'h02, 8'hFA);
    rd(6'h02, 8'hFD, "R5 cfg low bits strap");

    strap_active_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R6 active follows strap", active_o, 1);
    rd(6'h03, 8'h01, "R6 power reg strap");

    wr(6'h03, 8'h80);
    chk("R6 written standby", active_o, 0);
    chk("R7 res kept on takeover", res_o, 5);
    strap_res_i = 3'd7;
    strap_active_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R7 res ignores strap", res_o, 5);
    chk("R7 active ignores strap", active_o, 0);
    wr(6'h02, 8'h06);
    chk("R7 res from register", res_o, 6);
    rd(6'h02, 8'h06, "R7 cfg read sw");
    wr(6'h03, 8'h81);
    chk("R6 written active", active_o, 1);
    rd(6'h03, 8'h81, "R6 power read sw");

    wr(6'h2A, 8'h77);
    rd(6'h2A, 8'h00, "R9 unmapped read");
    rd(6'h00, 8'hAA, "R9 scratch untouched");

    // aborted write
    send_hdr(6'h00, 1'b0);
    clk_bit(1'b0);
    for (int i = 0; i < 4; i++) clk_bit(1'b1);
    end_frame();
    rd(6'h00, 8'hAA, "R8 aborted write");

    // aborted read
    send_hdr(6'h00, 1'b1);
    clk_bit(1'b0);
    #HALF sck_i = 1'b1;
    #HALF sck_i = 1'b0;
    #HALF chk("R8 oe during partial read", sdio_oe_o, 1);
    cs_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    chk("R8 oe after abort", sdio_oe_o, 0);
    #HALF;
    rd(6'h03, 8'h81, "R8 R1 read after abort");

    chk("R1 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule